// File: doc/BRIEF.md
# Register Pair Arithmetic Unit

This block carries out the 16-bit register-pair operations of an 8-bit processor core. There are three of them. One adds a pair to HL. One steps a pair up by one. One steps a pair down by one. Each clock the block takes an opcode, the current contents of the four pairs (BC, DE, HL, SP) and the flag byte. It reports which pair is to be written back, the new 16-bit value, the new flag byte and the number of T-states the operation costs.

The decode and the arithmetic are purely combinational. A single register stage holds the result, so every output reflects the inputs presented at the previous rising clock edge. Any opcode outside the three families is reported as not handled. In that case the flag byte passes through unchanged and the value and cost read as zero.

The decode sorts each opcode into one of four kinds, and the output process handles each kind in its own branch. The kinds are NONE (opcode not handled), ADD (HL plus a pair), INC (pair plus one) and DEC (pair minus one). The block holds no sequence between cycles. The output register either loads the result of the current kind on every edge, or returns to the NONE result while reset is asserted.

Top module: `rpa_unit`

## Requirements
- R1: An opcode with bits [7:6] = 00 is handled when its low nibble is 0x9 (ADD), 0x3 (INC) or 0xB (DEC). Bits [5:4] give the pair index n: 0 = BC, 1 = DE, 2 = HL, 3 = SP. A handled opcode sets `res_valid` to 1. `res_sel` is n for INC and DEC, and 2 (HL) for ADD.
- R2: ADD produces HL + pair(n) modulo 2^16.
- R3: After ADD, flag bit 0 (carry) is the carry out of bit 15 and flag bit 4 (half-carry) is the carry out of bit 11. Flag bit 1 (subtract) is cleared. Bits 7, 6, 5, 3 and 2 are copied from the input flag byte.
- R4: INC produces pair(n) + 1 and DEC produces pair(n) − 1, both wrapping modulo 2^16. For example, 0xFFFF steps up to 0x0000 and 0x0000 steps down to 0xFFFF.
- R5: INC and DEC pass the flag byte through unchanged.
- R6: `tstates` is 11 for ADD and 6 for INC or DEC. An opcode that is not handled gives `res_valid` = 0, `res_sel` = 0, `res_value` = 0, `tstates` = 0, and a flag byte equal to the input flag byte.
- R7: All outputs are registered. A change at the inputs becomes visible only after the next rising clock edge. While `rst_n` is low, every output is 0.
- R8: ADD with n = 2 doubles HL, using HL as both operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 8 | Opcode to execute |
| pair_bc | input | 16 | Current BC |
| pair_de | input | 16 | Current DE |
| pair_hl | input | 16 | Current HL |
| pair_sp | input | 16 | Current SP |
| flags_in | input | 8 | Current flag byte |
| res_valid | output | 1 | Opcode was one of the three handled families |
| res_sel | output | 2 | Index of the pair to write back |
| res_value | output | 16 | New value for that pair |
| flags_out | output | 8 | New flag byte |
| tstates | output | 5 | T-state cost |

## Verification
Two effects of ADD can land in the same cycle: a carry out of bit 11 and a carry out of bit 15. Adding HL to itself with HL = 0x8800, or adding SP = 0xFFFF to that HL, triggers both at once. The test then checks that bits 0 and 4 are both set, that bit 1 is cleared even when it was set on input, and that the five untouched bits are unchanged. A second overlap comes from ADD HL,HL itself, where the pair being read is also the pair being written. The expected doubled value and the write-back index of HL are compared together in the same check.

// File: rtl/rpa_pkg.sv
package rpa_pkg;

    typedef enum logic [1:0] {
        OPK_NONE = 2'd0,
        OPK_ADD  = 2'd1,
        OPK_INC  = 2'd2,
        OPK_DEC  = 2'd3
    } opkind_e;

    // flag byte bit positions
    localparam int FLG_C = 0;
    localparam int FLG_N = 1;
    localparam int FLG_H = 4;

    // opcode fields
    localparam logic [3:0] LO_ADD = 4'h9;
    localparam logic [3:0] LO_INC = 4'h3;
    localparam logic [3:0] LO_DEC = 4'hB;

    localparam int T_ADD  = 11;
    localparam int T_STEP = 6;

    localparam logic [1:0] IDX_HL = 2'd2;

endpackage

// File: rtl/rpa_decode.sv
module rpa_decode
    import rpa_pkg::*;
#(
    parameter int OPW = 8,
    parameter int SW  = 2
) (
    input  logic [OPW-1:0] opcode,
    output opkind_e        kind,
    output logic [SW-1:0]  src_sel,
    output logic [SW-1:0]  dst_sel
);
    localparam int HI_LSB = 4 + SW;

    logic upper_clear;

    always_comb begin
        upper_clear = (opcode[OPW-1:HI_LSB] == '0);
        src_sel     = opcode[HI_LSB-1:4];
        kind        = OPK_NONE;
        if (upper_clear) begin
            unique case (opcode[3:0])
                LO_ADD:  kind = OPK_ADD;
                LO_INC:  kind = OPK_INC;
                LO_DEC:  kind = OPK_DEC;
                default: kind = OPK_NONE;
            endcase
        end
        dst_sel = (kind == OPK_ADD) ? SW'(IDX_HL) : src_sel;
    end

endmodule

// File: rtl/rpa_pair_mux.sv
module rpa_pair_mux #(
    parameter int W  = 16,
    parameter int NP = 4,
    parameter int SW = $clog2(NP)
) (
    input  logic [NP*W-1:0] pairs_flat,
    input  logic [SW-1:0]   sel,
    output logic [W-1:0]    value
);
    logic [W-1:0] bank [NP];

    for (genvar g = 0; g < NP; g++) begin : g_split
        assign bank[g] = pairs_flat[g*W +: W];
    end

    assign value = bank[sel];

endmodule

// File: rtl/rpa_alu16.sv
module rpa_alu16
    import rpa_pkg::*;
#(
    parameter int W    = 16,
    parameter int FW   = 8,
    parameter int TW   = 5,
    parameter int HBIT = 11
) (
    input  opkind_e        kind,
    input  logic [W-1:0]   hl,
    input  logic [W-1:0]   src,
    input  logic [FW-1:0]  flags_in,
    output logic [W-1:0]   value,
    output logic [FW-1:0]  flags_out,
    output logic [TW-1:0]  tstates
);
    localparam int LW = HBIT + 1;

    logic [W:0]  full_sum;
    logic [LW:0] low_sum;

    always_comb begin
        full_sum  = {1'b0, hl} + {1'b0, src};
        low_sum   = {1'b0, hl[LW-1:0]} + {1'b0, src[LW-1:0]};
        value     = '0;
        flags_out = flags_in;
        tstates   = '0;
        unique case (kind)
            OPK_ADD: begin
                value            = full_sum[W-1:0];
                flags_out[FLG_C] = full_sum[W];
                flags_out[FLG_H] = low_sum[LW];
                flags_out[FLG_N] = 1'b0;
                tstates          = TW'(T_ADD);
            end
            OPK_INC: begin
                value   = src + W'(1);
                tstates = TW'(T_STEP);
            end
            OPK_DEC: begin
                value   = src - W'(1);
                tstates = TW'(T_STEP);
            end
            default: begin
                value     = '0;
                flags_out = flags_in;
                tstates   = '0;
            end
        endcase
    end

endmodule

// File: rtl/rpa_unit.sv
module rpa_unit
    import rpa_pkg::*;
#(
    parameter int W  = 16,
    parameter int FW = 8,
    parameter int TW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    opcode,
    input  logic [W-1:0]  pair_bc,
    input  logic [W-1:0]  pair_de,
    input  logic [W-1:0]  pair_hl,
    input  logic [W-1:0]  pair_sp,
    input  logic [FW-1:0] flags_in,
    output logic          res_valid,
    output logic [1:0]    res_sel,
    output logic [W-1:0]  res_value,
    output logic [FW-1:0] flags_out,
    output logic [TW-1:0] tstates
);
    localparam int NP = 4;
    localparam int SW = 2;

    opkind_e       kind;
    logic [SW-1:0] src_sel;
    logic [SW-1:0] dst_sel;
    logic [W-1:0]  src_val;
    logic [W-1:0]  nxt_value;
    logic [FW-1:0] nxt_flags;
    logic [TW-1:0] nxt_t;

    rpa_decode #(.OPW(8), .SW(SW)) i_dec (
        .opcode  (opcode),
        .kind    (kind),
        .src_sel (src_sel),
        .dst_sel (dst_sel)
    );

    rpa_pair_mux #(.W(W), .NP(NP), .SW(SW)) i_mux (
        .pairs_flat ({pair_sp, pair_hl, pair_de, pair_bc}),
        .sel        (src_sel),
        .value      (src_val)
    );

    rpa_alu16 #(.W(W), .FW(FW), .TW(TW), .HBIT(11)) i_alu (
        .kind      (kind),
        .hl        (pair_hl),
        .src       (src_val),
        .flags_in  (flags_in),
        .value     (nxt_value),
        .flags_out (nxt_flags),
        .tstates   (nxt_t)
    );

    // result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_sel   <= '0;
            res_value <= '0;
            flags_out <= '0;
            tstates   <= '0;
        end else begin
            res_valid <= (kind != OPK_NONE);
            res_sel   <= (kind != OPK_NONE) ? dst_sel : '0;
            res_value <= nxt_value;
            flags_out <= nxt_flags;
            tstates   <= nxt_t;
        end
    end

    // an unhandled opcode leaves the flags alone and reports nothing
    p_unhandled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode[7:6] != 2'b00) |=> (!res_valid && tstates == '0
                                    && flags_out == $past(flags_in)));

    // the step operations keep every flag bit
    p_step_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode[7:6] == 2'b00 && opcode[2:0] == 3'b011)
            |=> (flags_out == $past(flags_in) && tstates == TW'(T_STEP)));

    // the add leaves the five untouched flag bits and clears subtract
    p_add_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode[7:6] == 2'b00 && opcode[3:0] == LO_ADD)
            |=> ((flags_out & 8'hEC) == ($past(flags_in) & 8'hEC)
                 && !flags_out[FLG_N] && res_sel == IDX_HL));

    // the add cost
    p_add_cost_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 8'h09) |=> (tstates == TW'(T_ADD) && res_valid));

    // stepping BC up from all ones wraps to zero
    p_inc_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 8'h03 && pair_bc == '1) |=> (res_value == '0));

    // stepping DE down from zero wraps to all ones
    p_dec_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 8'h1B && pair_de == '0) |=> (res_value == '1));

endmodule

// File: tb/test_rpa_unit.sv
module test_rpa_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  opcode = '0;
    logic [15:0] pair_bc = '0, pair_de = '0, pair_hl = '0, pair_sp = '0;
    logic [7:0]  flags_in = '0;
    logic        res_valid;
    logic [1:0]  res_sel;
    logic [15:0] res_value;
    logic [7:0]  flags_out;
    logic [4:0]  tstates;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    rpa_unit i_rpa_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .opcode    (opcode),
        .pair_bc   (pair_bc),
        .pair_de   (pair_de),
        .pair_hl   (pair_hl),
        .pair_sp   (pair_sp),
        .flags_in  (flags_in),
        .res_valid (res_valid),
        .res_sel   (res_sel),
        .res_value (res_value),
        .flags_out (flags_out),
        .tstates   (tstates)
    );

    // op, bc, de, hl, sp, flags | valid, sel, value, flags, t
    localparam int NV = 15;
    localparam logic [111:0] VEC [NV] = '{
        {8'h09, 16'h1234, 16'h0FFF, 16'h8800, 16'hFFFF, 8'hFF, 1'b1, 2'd2, 16'h9A34, 8'hEC, 5'd11},
        {8'h19, 16'h1234, 16'h0FFF, 16'h8800, 16'hFFFF, 8'h00, 1'b1, 2'd2, 16'h97FF, 8'h10, 5'd11},
        {8'h29, 16'h1234, 16'h0FFF, 16'h8800, 16'hFFFF, 8'h02, 1'b1, 2'd2, 16'h1000, 8'h11, 5'd11},
        {8'h39, 16'h1234, 16'h0FFF, 16'h8800, 16'hFFFF, 8'hC4, 1'b1, 2'd2, 16'h87FF, 8'hD5, 5'd11},
        {8'h03, 16'h1234, 16'h0FFF, 16'h8800, 16'hFFFF, 8'h5A, 1'b1, 2'd0, 16'h1235, 8'h5A, 5'd6},
        {8'h13, 16'h1234, 16'h0FFF, 16'h8800, 16'hFFFF, 8'h00, 1'b1, 2'd1, 16'h1000, 8'h00, 5'd6},
        {8'h23, 16'h1234, 16'h0FFF, 16'h8800, 16'hFFFF, 8'hFF, 1'b1, 2'd2, 16'h8801, 8'hFF, 5'd6},
        {8'h33, 16'h1234, 16'h0FFF, 16'h8800, 16'hFFFF, 8'h81, 1'b1, 2'd3, 16'h0000, 8'h81, 5'd6},
        {8'h0B, 16'h1234, 16'h0FFF, 16'h8800, 16'hFFFF, 8'h13, 1'b1, 2'd0, 16'h1233, 8'h13, 5'd6},
        {8'h1B, 16'h1234, 16'h0FFF, 16'h8800, 16'hFFFF, 8'h00, 1'b1, 2'd1, 16'h0FFE, 8'h00, 5'd6},
        {8'h2B, 16'h1234, 16'h0FFF, 16'h8800, 16'hFFFF, 8'hAA, 1'b1, 2'd2, 16'h87FF, 8'hAA, 5'd6},
        {8'h3B, 16'h1234, 16'h0FFF, 16'h8800, 16'hFFFF, 8'h01, 1'b1, 2'd3, 16'hFFFE, 8'h01, 5'd6},
        {8'h00, 16'h1234, 16'h0FFF, 16'h8800, 16'hFFFF, 8'h77, 1'b0, 2'd0, 16'h0000, 8'h77, 5'd0},
        {8'h07, 16'h1234, 16'h0FFF, 16'h8800, 16'hFFFF, 8'h3C, 1'b0, 2'd0, 16'h0000, 8'h3C, 5'd0},
        {8'h4B, 16'h1234, 16'h0FFF, 16'h8800, 16'hFFFF, 8'h55, 1'b0, 2'd0, 16'h0000, 8'h55, 5'd0}
    };

    task automatic check(input string req, input logic v, input logic [1:0] s,
                         input logic [15:0] val, input logic [7:0] f, input logic [4:0] t);
        total++;
        if (res_valid !== v || res_sel !== s || res_value !== val
            || flags_out !== f || tstates !== t) begin
            bad++;
            $display("FAIL %s: got v=%b sel=%0d val=%h fl=%h t=%0d exp v=%b sel=%0d val=%h fl=%h t=%0d",
                     req, res_valid, res_sel, res_value, flags_out, tstates, v, s, val, f, t);
        end
    endtask

    task automatic drive(input logic [7:0] op, input logic [15:0] bc, input logic [15:0] de,
                         input logic [15:0] hl, input logic [15:0] sp, input logic [7:0] fl);
        @(negedge clk);
        opcode = op; pair_bc = bc; pair_de = de; pair_hl = hl; pair_sp = sp; flags_in = fl;
        @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        #200000;
        bad++; total++;
        $display("FAIL watchdog: got hung run, exp completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        string tag;
        // R7: reset state, even with a handled opcode on the inputs
        opcode = 8'h09; pair_hl = 16'h1111; flags_in = 8'hFF;
        repeat (3) @(posedge clk);
        #1;
        check("R7 reset", 1'b0, 2'd0, 16'h0000, 8'h00, 5'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][111:104], VEC[i][103:88], VEC[i][87:72],
                  VEC[i][71:56], VEC[i][55:40], VEC[i][39:32]);
            if (VEC[i][31] == 1'b0)       tag = "R6 unhandled";
            else if (VEC[i][4:0] == 5'd11) tag = (VEC[i][111:104] == 8'h29) ? "R1 R2 R3 R8" : "R1 R2 R3 R6";
            else                            tag = "R1 R4 R5 R6";
            check(tag, VEC[i][31], VEC[i][30:29], VEC[i][28:13], VEC[i][12:5], VEC[i][4:0]);
        end

        // R4: step down from zero wraps
        drive(8'h1B, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 8'h40);
        check("R4 dec wrap", 1'b1, 2'd1, 16'hFFFF, 8'h40, 5'd6);

        // R8 with R3: doubling HL with no carries keeps carry and half-carry clear
        drive(8'h29, 16'hFFFF, 16'hFFFF, 16'h0123, 16'hFFFF, 8'h13);
        check("R8 double", 1'b1, 2'd2, 16'h0246, 8'h00, 5'd11);

        // R7: new inputs are not seen before the next edge
        @(negedge clk);
        opcode = 8'h3B; pair_sp = 16'h0001; flags_in = 8'h99;
        #1;
        check("R7 latency", 1'b1, 2'd2, 16'h0246, 8'h00, 5'd11);
        @(posedge clk);
        #1;
        check("R7 latency after edge", 1'b1, 2'd3, 16'h0000, 8'h99, 5'd6);

        // R7: reset mid-run clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R7 async reset", 1'b0, 2'd0, 16'h0000, 8'h00, 5'd0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule